// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block is a frame-oriented serial audio sender. It is the master of its link: it produces a bit clock by dividing the block clock, a frame sync pulse and one serial data line. The samples come from a 32-entry transmit queue of 32-bit words. The frame shape is set through static configuration inputs. These give the number of words per frame, a separate width for the first word and for the remaining words, the sync pulse length, the sync polarity and an option to assert sync one bit early. A starting bit index and a shift direction choose which bits of each queued word are sent.

A transfer engine or a processor pushes words into the queue. The block raises a request output while the queue fill is at or below a programmable watermark. If a word is due while the queue is empty, the block sends zeros in its place and latches a sticky error. The error stays set until it is cleared with a one on the clear input, and it can drive an interrupt output. The bit clock enable and the transmit enable are separate. The configuration is expected to change only while transmission is off.

Top module: `ser_audio_tx`

## Requirements
- R1: While `bclk_en` is high, the internal bit clock toggles every `cfg_div`+1 block clocks, so one bit period is 2*(`cfg_div`+1) block clocks. Its first phase after enable is low.
- R2: `bclk` is the internal bit clock XOR `cfg_bclk_inv`. `sdata` and the internal sync change only on the block clock edge where the internal bit clock goes from 0 to 1. With `cfg_bclk_inv`=1 this is the falling edge of `bclk`, so a receiver can sample on the rising edge.
- R3: A frame holds `cfg_words_m1`+1 words sent back to back. Word 0 is `cfg_w0_len_m1`+1 bits long and every later word is `cfg_wn_len_m1`+1 bits long.
- R4: With early sync off, the sync is active during the first `cfg_sync_len_m1`+1 bits of each frame. Its active level is 1, or 0 when `cfg_sync_low`=1.
- R5: With early sync on, the sync covers the last bit of the previous frame and the first `cfg_sync_len_m1` bits of the frame. The first frame after enable is preceded by one extra bit slot with the sync active and data 0.
- R6: Bit k (k=0 first) of a word is source bit `cfg_first_bit`-k when `cfg_msb_first`=1, and `cfg_first_bit`+k when it is 0, both taken modulo 32.
- R7: The queue holds 32 words and `fifo_level` gives its fill. `fifo_full` is high at 32, and a write while full is dropped. One word is removed at the first bit of each transmitted word.
- R8: `dma_req` = `cfg_req_en` AND (`fifo_level` <= `cfg_watermark`).
- R9: When a word starts with the queue empty, its bits are 0 and `err_flag` sets. The flag holds until `err_clr` is high on a clock edge with no new underrun on that edge. A new underrun wins over a clear.
- R10: `irq` = `err_flag` AND `cfg_err_irq_en`.
- R11: While `tx_en` is low, `sdata` is 0, the sync is inactive and no word leaves the queue. The frame restarts from word 0 when transmission is next enabled.
- R12: While `bclk_en` is low, `bclk` equals `cfg_bclk_inv` and the divider is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock, source of the bit clock |
| rst_n | input | 1 | asynchronous reset, active low |
| tx_en | input | 1 | transmission enable |
| bclk_en | input | 1 | bit clock enable |
| cfg_div | input | 8 | bit clock divider value |
| cfg_bclk_inv | input | 1 | bit clock output inversion |
| cfg_words_m1 | input | 5 | words per frame minus one |
| cfg_sync_len_m1 | input | 5 | sync length in bits minus one |
| cfg_sync_low | input | 1 | sync active low |
| cfg_sync_early | input | 1 | sync one bit early |
| cfg_w0_len_m1 | input | 5 | word 0 width minus one |
| cfg_wn_len_m1 | input | 5 | width of later words minus one |
| cfg_first_bit | input | 5 | source index of the first bit sent |
| cfg_msb_first | input | 1 | 1: index decreases, 0: index increases |
| cfg_watermark | input | 5 | request threshold |
| cfg_req_en | input | 1 | request output enable |
| cfg_err_irq_en | input | 1 | error interrupt enable |
| wr_en | input | 1 | queue write strobe |
| wr_data | input | 32 | queue write word |
| err_clr | input | 1 | write-one clear of the error flag |
| fifo_full | output | 1 | queue full |
| fifo_level | output | 6 | queue fill |
| bclk | output | 1 | bit clock |
| fsync | output | 1 | frame sync |
| sdata | output | 1 | serial data |
| dma_req | output | 1 | refill request |
| err_flag | output | 1 | sticky underrun flag |
| irq | output | 1 | error interrupt |

## Verification
The assertions assume that the configuration inputs stay constant while `tx_en` is high. They also assume that the sync length fits inside one frame and that the bench never writes when `fifo_full` is high and no word is leaving in the same cycle. The stimulus changes configuration only in phases where transmission is off. It picks sync lengths shorter than the frame. It fills the queue past full only while transmission is stopped. It starves the queue on purpose to provoke underruns, and it clears the error both while underruns continue and after they have stopped.

// File: rtl/ser_audio_tx_pkg.sv
package ser_audio_tx_pkg;
   localparam int FLD_W = 5;

   typedef struct packed {
      logic [FLD_W-1:0] words_m1;
      logic [FLD_W-1:0] sync_m1;
      logic [FLD_W-1:0] w0_m1;
      logic [FLD_W-1:0] wn_m1;
      logic [FLD_W-1:0] first_bit;
      logic             early;
      logic             msb_first;
   } frame_cfg_t;
endpackage

// File: rtl/ser_audio_tx_clkdiv.sv
module ser_audio_tx_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             bclk_int,
   output logic             launch
);
   logic [DIV_W-1:0] cnt_q;

   // launch marks the edge on which the internal bit clock rises
   assign launch = en && (cnt_q == div) && !bclk_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         bclk_int <= 1'b0;
      end else if (!en) begin
         cnt_q    <= '0;
         bclk_int <= 1'b0;
      end else if (cnt_q == div) begin
         cnt_q    <= '0;
         bclk_int <= ~bclk_int;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: the clock never toggles off the terminal count
   assert_toggle_at_terminal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt_q != div) |=> $stable(bclk_int));
endmodule

// File: rtl/ser_audio_tx_fifo.sv
module ser_audio_tx_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full,
   output logic [LVL_W-1:0]  level
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
   logic [LVL_W-1:0]  level_q;
   logic              push, take;

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
      $error("queue depth must be a power of two");
   end

   assign full  = (level_q == LVL_W'(DEPTH));
   assign empty = (level_q == '0);
   assign level = level_q;
   assign head  = mem[rd_ptr_q];
   assign push  = wr_en && !full;
   assign take  = pop && !empty;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (take) rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push, take})
            2'b10:   level_q <= level_q + 1'b1;
            2'b01:   level_q <= level_q - 1'b1;
            default: level_q <= level_q;
         endcase
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVL_W'(DEPTH));
   assert_fill_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !take) |=> (level_q == $past(level_q) + 1'b1));
endmodule

// File: rtl/ser_audio_tx_framer.sv
module ser_audio_tx_framer
   import ser_audio_tx_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DATA_W),
   localparam int FB_W  = 2 * FLD_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              launch,
   input  frame_cfg_t        cfg,
   input  logic [DATA_W-1:0] head,
   input  logic              empty,
   output logic              pop,
   output logic              underrun,
   output logic              sd,
   output logic              fs_act
);
   logic [FLD_W-1:0]  word_q, bit_q, width_m1;
   logic [FB_W-1:0]   fbit_q;
   logic              started_q, sd_q, fs_q;
   logic [DATA_W-1:0] hold_q, cur;
   logic [IDX_W-1:0]  bidx;
   logic              lead_slot, slot, word_start, word_end, frame_end, sync_now;

   if ((DATA_W & (DATA_W - 1)) != 0 || IDX_W > FLD_W) begin : g_width_chk
      $error("word width must be a power of two addressable by the bit field");
   end

   always_comb begin
      lead_slot  = tx_en && launch && !started_q && cfg.early;
      slot       = tx_en && launch && !lead_slot;
      width_m1   = (word_q == '0) ? cfg.w0_m1 : cfg.wn_m1;
      word_start = (bit_q == '0);
      word_end   = (bit_q == width_m1);
      frame_end  = word_end && (word_q == cfg.words_m1);
      cur        = word_start ? (empty ? '0 : head) : hold_q;
      if (cfg.msb_first) bidx = IDX_W'(cfg.first_bit) - IDX_W'(bit_q);
      else               bidx = IDX_W'(cfg.first_bit) + IDX_W'(bit_q);
      if (cfg.early) sync_now = frame_end || (fbit_q < FB_W'(cfg.sync_m1));
      else           sync_now = (fbit_q <= FB_W'(cfg.sync_m1));
   end

   assign pop      = slot && word_start && !empty;
   assign underrun = slot && word_start && empty;
   assign sd       = sd_q;
   assign fs_act   = fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0; bit_q <= '0; fbit_q <= '0; started_q <= 1'b0;
         hold_q <= '0; sd_q <= 1'b0; fs_q <= 1'b0;
      end else if (!tx_en) begin
         word_q <= '0; bit_q <= '0; fbit_q <= '0; started_q <= 1'b0;
         sd_q <= 1'b0; fs_q <= 1'b0;
      end else if (lead_slot) begin
         started_q <= 1'b1;
         sd_q      <= 1'b0;
         fs_q      <= 1'b1;
      end else if (slot) begin
         started_q <= 1'b1;
         sd_q      <= cur[bidx];
         fs_q      <= sync_now;
         if (word_start) hold_q <= cur;
         if (frame_end) begin
            word_q <= '0; bit_q <= '0; fbit_q <= '0;
         end else if (word_end) begin
            word_q <= word_q + 1'b1; bit_q <= '0; fbit_q <= fbit_q + 1'b1;
         end else begin
            bit_q <= bit_q + 1'b1; fbit_q <= fbit_q + 1'b1;
         end
      end
   end

   // R2: outputs move only on a launch edge while enabled
   assert_hold_between_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !launch) |=> ($stable(sd_q) && $stable(fs_q)));
endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
   import ser_audio_tx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int DIV_W  = 8,
   localparam int WMK_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              bclk_en,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_bclk_inv,
   input  logic [FLD_W-1:0]  cfg_words_m1,
   input  logic [FLD_W-1:0]  cfg_sync_len_m1,
   input  logic              cfg_sync_low,
   input  logic              cfg_sync_early,
   input  logic [FLD_W-1:0]  cfg_w0_len_m1,
   input  logic [FLD_W-1:0]  cfg_wn_len_m1,
   input  logic [FLD_W-1:0]  cfg_first_bit,
   input  logic              cfg_msb_first,
   input  logic [WMK_W-1:0]  cfg_watermark,
   input  logic              cfg_req_en,
   input  logic              cfg_err_irq_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              err_clr,
   output logic              fifo_full,
   output logic [LVL_W-1:0]  fifo_level,
   output logic              bclk,
   output logic              fsync,
   output logic              sdata,
   output logic              dma_req,
   output logic              err_flag,
   output logic              irq
);
   frame_cfg_t        fcfg;
   logic              bclk_int, launch, pop, underrun, fs_act, empty, err_q;
   logic [DATA_W-1:0] head;

   if (DIV_W < 1 || DEPTH < 2) begin : g_param_chk
      $error("divider width or queue depth out of range");
   end

   assign fcfg = '{words_m1: cfg_words_m1, sync_m1: cfg_sync_len_m1,
                   w0_m1: cfg_w0_len_m1, wn_m1: cfg_wn_len_m1,
                   first_bit: cfg_first_bit, early: cfg_sync_early,
                   msb_first: cfg_msb_first};

   ser_audio_tx_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(bclk_en), .div(cfg_div),
      .bclk_int(bclk_int), .launch(launch));

   ser_audio_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
      .head(head), .empty(empty), .full(fifo_full), .level(fifo_level));

   ser_audio_tx_framer #(.DATA_W(DATA_W)) u_frm (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .launch(launch), .cfg(fcfg),
      .head(head), .empty(empty), .pop(pop), .underrun(underrun),
      .sd(sdata), .fs_act(fs_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_q <= 1'b0;
      else if (underrun) err_q <= 1'b1;
      else if (err_clr)  err_q <= 1'b0;
   end

   assign bclk     = bclk_int ^ cfg_bclk_inv;
   assign fsync    = fs_act ^ cfg_sync_low;
   assign dma_req  = cfg_req_en && (fifo_level <= LVL_W'(cfg_watermark));
   assign err_flag = err_q;
   assign irq      = err_q && cfg_err_irq_en;

   assert_underrun_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> err_flag);
   assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!sdata && (fsync == cfg_sync_low)));
   assert_clock_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bclk_en |=> (bclk == cfg_bclk_inv));
endmodule

// File: tb/tb_ser_audio_tx.sv
module tb_ser_audio_tx;
   localparam int CLK_P = 10;
   localparam int WD_LIMIT = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tx_en = 0, bclk_en = 0, cfg_bclk_inv = 0, cfg_sync_low = 0, cfg_sync_early = 0;
   logic cfg_msb_first = 1, cfg_req_en = 0, cfg_err_irq_en = 0, wr_en = 0, err_clr = 0;
   logic [7:0]  cfg_div = 0;
   logic [4:0]  cfg_words_m1 = 0, cfg_sync_len_m1 = 0, cfg_w0_len_m1 = 0, cfg_wn_len_m1 = 0;
   logic [4:0]  cfg_first_bit = 0, cfg_watermark = 0;
   logic [31:0] wr_data = 0;
   logic        fifo_full, bclk, fsync, sdata, dma_req, err_flag, irq;
   logic [5:0]  fifo_level;

   always #(CLK_P/2) clk = ~clk;

   ser_audio_tx dut (.*);

   int checks = 0, fails = 0, cycles = 0;
   bit done = 0;

   // behavioural reference state
   int m_cnt, m_bint, m_started, m_word, m_bit, m_fbit, m_sd, m_fs, m_err;
   logic [31:0] m_hold;
   logic [31:0] q[$];

   task automatic chk(input string tag, input string sig, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, sig, cycles, got, exp);
      end
   endtask

   task automatic model_step();
      int tick, push_ok, wlen, idx, sync;
      logic [31:0] cur;
      if (!rst_n) begin
         m_cnt = 0; m_bint = 0; m_started = 0; m_word = 0; m_bit = 0; m_fbit = 0;
         m_sd = 0; m_fs = 0; m_err = 0; m_hold = 0; q.delete();
         return;
      end
      tick    = (bclk_en && m_cnt == int'(cfg_div) && m_bint == 0) ? 1 : 0;
      push_ok = (wr_en && q.size() < 32) ? 1 : 0;
      if (!tx_en) begin
         m_started = 0; m_word = 0; m_bit = 0; m_fbit = 0; m_sd = 0; m_fs = 0;
         if (err_clr) m_err = 0;
      end else if (tick && !m_started && cfg_sync_early) begin
         m_started = 1; m_sd = 0; m_fs = 1;
         if (err_clr) m_err = 0;
      end else if (tick) begin
         m_started = 1;
         wlen = (m_word == 0) ? int'(cfg_w0_len_m1) + 1 : int'(cfg_wn_len_m1) + 1;
         if (m_bit == 0) begin
            if (q.size() == 0) begin cur = 0; m_err = 1; end
            else begin cur = q.pop_front(); if (err_clr) m_err = 0; end
            m_hold = cur;
         end else begin
            cur = m_hold;
            if (err_clr) m_err = 0;
         end
         idx = cfg_msb_first ? (int'(cfg_first_bit) - m_bit) : (int'(cfg_first_bit) + m_bit);
         idx = ((idx % 32) + 32) % 32;
         if (cfg_sync_early)
            sync = ((m_word == int'(cfg_words_m1) && m_bit == wlen - 1) || m_fbit < int'(cfg_sync_len_m1)) ? 1 : 0;
         else
            sync = (m_fbit <= int'(cfg_sync_len_m1)) ? 1 : 0;
         m_sd = cur[idx];
         m_fs = sync;
         if (m_bit == wlen - 1) begin
            m_bit = 0;
            if (m_word == int'(cfg_words_m1)) begin m_word = 0; m_fbit = 0; end
            else begin m_word++; m_fbit++; end
         end else begin
            m_bit++; m_fbit++;
         end
      end else if (err_clr) m_err = 0;
      if (push_ok) q.push_back(wr_data);
      if (!bclk_en) begin m_cnt = 0; m_bint = 0; end
      else if (m_cnt == int'(cfg_div)) begin m_cnt = 0; m_bint = 1 - m_bint; end
      else m_cnt = (m_cnt + 1) % 256;
   endtask

   task automatic compare_all();
      string tb_tag, sd_tag, fs_tag;
      tb_tag = !bclk_en ? "R12" : (cfg_bclk_inv ? "R2" : "R1");
      sd_tag = !tx_en ? "R11" : (cfg_msb_first ? "R3" : "R6");
      fs_tag = !tx_en ? "R11" : (cfg_sync_early ? "R5" : "R4");
      chk(tb_tag, "bclk", bclk, m_bint ^ int'(cfg_bclk_inv));
      chk(sd_tag, "sdata", sdata, m_sd);
      chk(fs_tag, "fsync", fsync, m_fs ^ int'(cfg_sync_low));
      chk("R7", "fifo_level", fifo_level, q.size());
      chk("R7", "fifo_full", fifo_full, (q.size() == 32) ? 1 : 0);
      chk("R8", "dma_req", dma_req, (cfg_req_en && q.size() <= int'(cfg_watermark)) ? 1 : 0);
      chk("R9", "err_flag", err_flag, m_err);
      chk("R10", "irq", irq, (m_err != 0 && cfg_err_irq_en) ? 1 : 0);
   endtask

   always @(posedge clk) begin
      model_step();
      #(CLK_P/4);
      if (!done) begin
         cycles++;
         compare_all();
         if (cycles > WD_LIMIT) begin
            fails++;
            done = 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
         end
      end
   end

   task automatic push(input logic [31:0] d);
      wr_data = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle(4);
      // phase A: MSB first, 24-bit words in 32-bit slots, early active-low sync
      cfg_div = 1; cfg_bclk_inv = 0; cfg_words_m1 = 1; cfg_sync_len_m1 = 23;
      cfg_w0_len_m1 = 23; cfg_wn_len_m1 = 23; cfg_first_bit = 31; cfg_msb_first = 1;
      cfg_sync_early = 1; cfg_sync_low = 1; cfg_watermark = 4; cfg_req_en = 1;
      cfg_err_irq_en = 1;
      for (int i = 0; i < 8; i++) push(32'hA5C3_0F00 ^ (32'h0111_1111 * i));
      idle(6);
      bclk_en = 1;
      idle(21);
      tx_en = 1;
      idle(900);                    // queue drains, underrun follows
      err_clr = 1; idle(1); err_clr = 0;
      idle(60);
      tx_en = 0;
      idle(3);
      err_clr = 1; idle(1); err_clr = 0;
      idle(10);
      // phase B: inverted bit clock, three words of mixed width, LSB first
      bclk_en = 0;
      cfg_div = 0; cfg_bclk_inv = 1; cfg_words_m1 = 2; cfg_sync_len_m1 = 0;
      cfg_w0_len_m1 = 7; cfg_wn_len_m1 = 15; cfg_first_bit = 4; cfg_msb_first = 0;
      cfg_sync_early = 0; cfg_sync_low = 0; cfg_watermark = 2; cfg_err_irq_en = 0;
      for (int i = 0; i < 5; i++) push(32'h1357_9BDF + (32'h2468_0001 * i));
      idle(3);
      bclk_en = 1; tx_en = 1;
      for (int i = 0; i < 20; i++) begin
         push(32'hF00D_0000 | (i * 32'h0000_0F1F));
         idle(29);
      end
      idle(120);
      tx_en = 0; bclk_en = 0;
      idle(5);
      err_clr = 1; idle(1); err_clr = 0;
      // phase C: overfill while stopped, then run a short burst
      cfg_watermark = 31; cfg_err_irq_en = 1;
      for (int i = 0; i < 34; i++) push(32'h8000_0001 + (i << 7));
      idle(4);
      cfg_div = 3; cfg_first_bit = 15; cfg_msb_first = 1; cfg_words_m1 = 0;
      cfg_w0_len_m1 = 15; cfg_sync_len_m1 = 3; cfg_sync_early = 1; cfg_sync_low = 0;
      bclk_en = 1;
      idle(5);
      tx_en = 1;
      idle(400);
      tx_en = 0;
      idle(20);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule